// File: doc/BRIEF.md
# Reply Receiver Gate Controller

This block holds the video-enable level for a reply receiver and decides when to drop it while a transponder reply is coming in. An arm strobe opens the receive window. The first framing pulse of the reply then starts an internal tap timer. Every framing pulse, the first one included, also enters a small delay pipeline whose outputs step a train counter. All delays are counted in sample ticks, so the block needs no analog delay line.

The point at which the window closes depends on the interrogation mode and on the kind of reply:
- In altitude mode, a fixed long tap closes the window.
- In the other modes, a short tap sets a line-drive latch. For a plain reply the window closes when the latch sets.
- For an identity reply outside mode 1, the window closes when the trailing edge of the identity pulse clears the latch.
- For a mode 1 identity reply and for an emergency reply, the delayed framing pulses are counted and the window closes on the second or the fourth of them.

A debug output reports the phase of the gate.

Top module: `reply_gate_ctrl`

## Requirements
- R1: After synchronous reset, `rx_en` is 0 and `gate_state` is 0 (closed).
- R2: An `arm_stb` sampled high sets `rx_en` to 1 and `gate_state` to 1 (listening) at that clock edge. It also clears the latch, the train counter, the first-seen flag and all pending delay timers. Arm wins over every other event in the same cycle.
- R3: With `mode` = 2'b10 (altitude), `rx_en` falls TAP_LONG ticks after the first accepted framing pulse. `gate_state` reads 2 (timing) until then and never reads 3, because the latch is not used in this mode.
- R4: With `mode` = 2'b00 or 2'b01 (2'b11 acts as 2'b01), `ident` = 0 and `emerg` = 0, `rx_en` falls TAP_SHORT ticks after the first accepted framing pulse.
- R5: With `mode` = 2'b01, `ident` = 1 and `emerg` = 0, the latch sets TAP_SHORT ticks after the first framing pulse (`gate_state` = 3) and the gate stays open. The gate closes at the clock edge that samples `idp_lvl` falling while the latch is set. A falling edge before the latch sets has no effect.
- R6: With `mode` = 2'b00, `ident` = 1 and `emerg` = 0, `rx_en` falls TAP_SHORT ticks after the second accepted framing pulse.
- R7: With `emerg` = 1 and a mode other than 2'b10, `rx_en` falls TAP_SHORT ticks after the fourth accepted framing pulse, whatever the value of `ident`. Delayed copies may overlap in flight, up to SLOTS at a time.
- R8: A framing pulse that arrives while the gate is closed is ignored, and the gate stays closed until the next arm.
- R9: Re-arming in the middle of a reply discards the timers already running, so the earlier framing pulse does not close the new window.
- R10: The delay timers advance only on clock edges where `tick` is high, so a gap in `tick` postpones the closing by exactly the number of missing ticks.
- R11: Only the first accepted framing pulse of a reply starts the long and short taps. A later pulse does not restart them, and `gate_state` moves from 1 to 2 on the first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample tick that advances the delay timers |
| mode | input | 2 | Interrogation mode: 00 mode 1, 01 mode 3, 10 altitude, 11 treated as mode 3 |
| ident | input | 1 | Identity reply expected |
| emerg | input | 1 | Emergency reply expected |
| frm_stb | input | 1 | One-cycle strobe for each reply framing pulse |
| idp_lvl | input | 1 | Identity pulse level |
| arm_stb | input | 1 | Opens the receive window and clears the reply state |
| rx_en | output | 1 | Registered receiver video enable |
| gate_state | output | 2 | Registered phase: 0 closed, 1 listening, 2 timing, 3 latched |

## Verification
A strobe sampled at edge E0 reaches `rx_en` and `gate_state` on that same edge, so an arm shows one cycle after it is driven. A tap closing shows D+1 cycles after the framing strobe is driven, where D is the delay in ticks. An identity-pulse closing shows on the edge that samples the low level.

Each expected value is queued with the exact cycle on which it is due. The checks bracket each closing with the last cycle on which the gate must still be open and the first cycle on which it must be shut. A monitor on the falling clock edge compares every item in its cycle and flags an item that was not examined on time.

// File: rtl/reply_gate_pkg.sv
package reply_gate_pkg;

  typedef enum logic [1:0] {
    MODE_1   = 2'b00,
    MODE_3   = 2'b01,
    MODE_ALT = 2'b10,
    MODE_RSV = 2'b11
  } rg_mode_e;

  typedef enum logic [1:0] {
    GS_CLOSED  = 2'd0,
    GS_LISTEN  = 2'd1,
    GS_TIMING  = 2'd2,
    GS_LATCHED = 2'd3
  } rg_state_e;

  typedef enum logic [2:0] {
    CR_TAP_LONG,
    CR_LATCH_SET,
    CR_LATCH_FALL,
    CR_COUNT2,
    CR_COUNT4
  } rg_rule_e;

  // Choose the event that ends the receive window; the order is the priority.
  function automatic rg_rule_e pick_rule(input logic [1:0] m, input logic id, input logic em);
    if (m == MODE_ALT)          return CR_TAP_LONG;
    else if (em)                return CR_COUNT4;
    else if (id && m == MODE_1) return CR_COUNT2;
    else if (id)                return CR_LATCH_FALL;
    else                        return CR_LATCH_SET;
  endfunction

endpackage

// File: rtl/rg_tap_timer.sv
module rg_tap_timer #(
  parameter int LIMIT = 250,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         start,
  input  logic         tick,
  output logic         busy,
  output logic [W-1:0] elapsed
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy    <= 1'b0;
      elapsed <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      elapsed <= '0;
    end else if (busy && tick) begin
      if (elapsed == LAST) begin
        busy    <= 1'b0;
        elapsed <= '0;
      end else begin
        elapsed <= elapsed + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rg_first_tap.sv
module rg_first_tap #(
  parameter int TAP_SHORT = 220,
  parameter int TAP_LONG  = 250,
  localparam int W = $clog2(TAP_LONG + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic frm_ok,
  input  logic tick,
  output logic seen_nxt,
  output logic tap_short,
  output logic tap_long
);
  localparam logic [W-1:0] SHORT_LAST = W'(TAP_SHORT - 1);
  localparam logic [W-1:0] LONG_LAST  = W'(TAP_LONG - 1);

  logic         seen_q;
  logic         busy;
  logic [W-1:0] elapsed;
  logic         start;

  assign start = frm_ok && !seen_q;

  rg_tap_timer #(.LIMIT(TAP_LONG)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .start   (start),
    .tick    (tick),
    .busy    (busy),
    .elapsed (elapsed)
  );

  assign tap_short = busy && tick && (elapsed == SHORT_LAST);
  assign tap_long  = busy && tick && (elapsed == LONG_LAST);

  always_comb begin
    if (clr) seen_nxt = 1'b0;
    else     seen_nxt = seen_q || frm_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= seen_nxt;
  end
endmodule

// File: rtl/rg_delay_pipe.sv
module rg_delay_pipe #(
  parameter int SLOTS = 4,
  parameter int DELAY = 220,
  localparam int W = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic push,
  input  logic tick,
  output logic fire
);
  localparam logic [W-1:0] LAST = W'(DELAY - 1);

  logic [SLOTS-1:0] busy;
  logic [SLOTS-1:0] load;
  logic [SLOTS-1:0] hit;
  logic [W-1:0]     elapsed [SLOTS];

  // Lowest free slot takes the new copy; a pulse with no free slot is dropped.
  always_comb begin
    logic taken;
    taken = 1'b0;
    load  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (push && !busy[i] && !taken) begin
        load[i] = 1'b1;
        taken   = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    rg_tap_timer #(.LIMIT(DELAY)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .start   (load[g]),
      .tick    (tick),
      .busy    (busy[g]),
      .elapsed (elapsed[g])
    );
    assign hit[g] = busy[g] && tick && (elapsed[g] == LAST);
  end

  assign fire = |hit;
endmodule

// File: rtl/rg_close_ctrl.sv
module rg_close_ctrl
  import reply_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [1:0] mode,
  input  logic       ident,
  input  logic       emerg,
  input  logic       tap_short,
  input  logic       tap_long,
  input  logic       pipe_fire,
  input  logic       idp_fall,
  output logic       latch_nxt,
  output logic       close
);
  logic       latch_q;
  logic [1:0] trains_q;
  logic [1:0] trains_nxt;
  logic       is_alt;
  logic       latch_drop;
  rg_rule_e   rule;

  assign is_alt     = (mode == MODE_ALT);
  assign rule       = pick_rule(mode, ident, emerg);
  assign latch_drop = latch_q && idp_fall;

  always_comb begin
    if (clr)                       latch_nxt = 1'b0;
    else if (tap_short && !is_alt) latch_nxt = 1'b1;
    else if (latch_drop)           latch_nxt = 1'b0;
    else                           latch_nxt = latch_q;
  end

  always_comb begin
    if (clr)                       trains_nxt = '0;
    else if (pipe_fire && !is_alt) trains_nxt = trains_q + 2'd1;
    else                           trains_nxt = trains_q;
  end

  always_comb begin
    close = 1'b0;
    if (!clr) begin
      unique case (rule)
        CR_TAP_LONG:   close = tap_long;
        CR_LATCH_SET:  close = tap_short;
        CR_LATCH_FALL: close = latch_drop;
        CR_COUNT2:     close = pipe_fire && (trains_q == 2'd1);
        CR_COUNT4:     close = pipe_fire && (trains_q == 2'd3);
        default:       close = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= 1'b0;
      trains_q <= '0;
    end else begin
      latch_q  <= latch_nxt;
      trains_q <= trains_nxt;
    end
  end
endmodule

// File: rtl/reply_gate_ctrl.sv
module reply_gate_ctrl
  import reply_gate_pkg::*;
#(
  parameter int TAP_SHORT = 220,
  parameter int TAP_LONG  = 250,
  parameter int SLOTS     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       ident,
  input  logic       emerg,
  input  logic       frm_stb,
  input  logic       idp_lvl,
  input  logic       arm_stb,
  output logic       rx_en,
  output logic [1:0] gate_state
);
  logic idp_q;
  logic idp_fall;
  logic frm_ok;
  logic seen_nxt;
  logic tap_short;
  logic tap_long;
  logic pipe_fire;
  logic latch_nxt;
  logic close;
  logic en_nxt;
  rg_state_e st_nxt;

  assign frm_ok   = frm_stb && rx_en && !arm_stb;
  assign idp_fall = idp_q && !idp_lvl;

  rg_first_tap #(.TAP_SHORT(TAP_SHORT), .TAP_LONG(TAP_LONG)) u_first (
    .clk       (clk),
    .rst       (rst),
    .clr       (arm_stb),
    .frm_ok    (frm_ok),
    .tick      (tick),
    .seen_nxt  (seen_nxt),
    .tap_short (tap_short),
    .tap_long  (tap_long)
  );

  rg_delay_pipe #(.SLOTS(SLOTS), .DELAY(TAP_SHORT)) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .clr  (arm_stb),
    .push (frm_ok),
    .tick (tick),
    .fire (pipe_fire)
  );

  rg_close_ctrl u_close (
    .clk       (clk),
    .rst       (rst),
    .clr       (arm_stb),
    .mode      (mode),
    .ident     (ident),
    .emerg     (emerg),
    .tap_short (tap_short),
    .tap_long  (tap_long),
    .pipe_fire (pipe_fire),
    .idp_fall  (idp_fall),
    .latch_nxt (latch_nxt),
    .close     (close)
  );

  always_comb begin
    if (arm_stb)    en_nxt = 1'b1;
    else if (close) en_nxt = 1'b0;
    else            en_nxt = rx_en;
  end

  always_comb begin
    if (!en_nxt)        st_nxt = GS_CLOSED;
    else if (latch_nxt) st_nxt = GS_LATCHED;
    else if (seen_nxt)  st_nxt = GS_TIMING;
    else                st_nxt = GS_LISTEN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en      <= 1'b0;
      gate_state <= GS_CLOSED;
      idp_q      <= 1'b0;
    end else begin
      rx_en      <= en_nxt;
      gate_state <= st_nxt;
      idp_q      <= idp_lvl;
    end
  end
endmodule

// File: rtl/reply_gate_chk.sv
module reply_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [1:0] mode,
  input logic       frm_stb,
  input logic       arm_stb,
  input logic       rx_en,
  input logic [1:0] gate_state
);
  AST_RESET_SHUT: assert property (@(posedge clk)
    rst |=> (!rx_en && gate_state == 2'd0)); // R1

  AST_ARM_OPENS: assert property (@(posedge clk) disable iff (rst)
    arm_stb |=> (rx_en && gate_state == 2'd1)); // R2

  AST_STAYS_SHUT: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !arm_stb) |=> !rx_en); // R8

  AST_ALT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (rx_en && !arm_stb && !tick && mode == 2'b10) |=> rx_en); // R10

  AST_FIRST_PULSE_TIMES: assert property (@(posedge clk) disable iff (rst)
    (rx_en && !arm_stb && frm_stb && gate_state == 2'd1) |=> (gate_state == 2'd2)); // R11

  AST_ALT_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && $stable(mode) && gate_state != 2'd3 && !arm_stb) |=> (gate_state != 2'd3)); // R3
endmodule

bind reply_gate_ctrl reply_gate_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .mode       (mode),
  .frm_stb    (frm_stb),
  .arm_stb    (arm_stb),
  .rx_en      (rx_en),
  .gate_state (gate_state)
);

// File: tb/reply_gate_ctrl_test.sv
module reply_gate_ctrl_test;
  localparam int TS = 22;
  localparam int TL = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       ident = 1'b0;
  logic       emerg = 1'b0;
  logic       frm_stb = 1'b0;
  logic       idp_lvl = 1'b0;
  logic       arm_stb = 1'b0;
  logic       rx_en;
  logic [1:0] gate_state;

  always #5 clk = ~clk;

  reply_gate_ctrl #(.TAP_SHORT(TS), .TAP_LONG(TL), .SLOTS(4)) uut (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .ident(ident), .emerg(emerg),
    .frm_stb(frm_stb), .idp_lvl(idp_lvl), .arm_stb(arm_stb),
    .rx_en(rx_en), .gate_state(gate_state)
  );

  typedef struct {
    int         cyc;
    logic       en;
    bit         use_st;
    logic [1:0] st;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard insert, kept sorted by due cycle.
  task automatic expect_at(input int c, input logic en, input bit use_st,
                           input logic [1:0] st, input string tag);
    exp_t e;
    int   pos;
    e.cyc = c; e.en = en; e.use_st = use_st; e.st = st; e.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].cyc > c) begin
        pos = i;
        break;
      end
    end
    q.insert(pos, e);
  endtask

  // Monitor: compares queued items on the falling edge of their cycle.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (e.cyc != cyc || rx_en !== e.en || (e.use_st && gate_state !== e.st)) begin
        n_fail++;
        $display("FAIL %s at cycle %0d (due %0d): rx_en=%b state=%0d expected rx_en=%b state=%0d",
                 e.tag, cyc, e.cyc, rx_en, gate_state, e.en, e.st);
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: run hung at cycle %0d, expected finish before 50000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic arm_gate(input logic [1:0] m, input logic id, input logic em, input string tag);
    mode = m; ident = id; emerg = em; arm_stb = 1'b1;
    expect_at(cyc + 1, 1'b1, 1'b1, 2'd1, tag);
    @(negedge clk);
    arm_stb = 1'b0;
  endtask

  task automatic frm_at(input int c);
    wait_to(c);
    frm_stb = 1'b1;
    @(negedge clk);
    frm_stb = 1'b0;
  endtask

  int c;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_at(cyc + 1, 1'b0, 1'b1, 2'd0, "R1");
    // R8: framing pulse before any arm
    c = cyc + 2;
    frm_at(c);
    expect_at(c + 30, 1'b0, 1'b1, 2'd0, "R8");
    drain();

    // R4 mode 3 plain reply
    arm_gate(2'b01, 1'b0, 1'b0, "R2");
    c = cyc + 3;
    frm_at(c);
    expect_at(c + 2,  1'b1, 1'b1, 2'd2, "R11");
    expect_at(c + TS, 1'b1, 1'b0, 2'd0, "R4");
    expect_at(c + TS + 1, 1'b0, 1'b1, 2'd0, "R4");
    drain();

    // R4 mode 1 plain reply
    arm_gate(2'b00, 1'b0, 1'b0, "R2");
    c = cyc + 3;
    frm_at(c);
    expect_at(c + TS, 1'b1, 1'b0, 2'd0, "R4");
    expect_at(c + TS + 1, 1'b0, 1'b1, 2'd0, "R4");
    drain();

    // R3 altitude mode: long tap, no latch
    arm_gate(2'b10, 1'b0, 1'b0, "R2");
    c = cyc + 3;
    frm_at(c);
    expect_at(c + TS + 1, 1'b1, 1'b1, 2'd2, "R3");
    expect_at(c + TL,     1'b1, 1'b1, 2'd2, "R3");
    expect_at(c + TL + 1, 1'b0, 1'b1, 2'd0, "R3");
    drain();

    // R11 second pulse does not restart the long tap
    arm_gate(2'b10, 1'b0, 1'b0, "R2");
    c = cyc + 3;
    frm_at(c);
    frm_at(c + 10);
    expect_at(c + 12,     1'b1, 1'b1, 2'd2, "R11");
    expect_at(c + TL,     1'b1, 1'b0, 2'd0, "R11");
    expect_at(c + TL + 1, 1'b0, 1'b1, 2'd0, "R11");
    drain();

    // R5 mode 3 identity: early fall ignored, latched fall closes
    arm_gate(2'b01, 1'b1, 1'b0, "R2");
    c = cyc + 3;
    frm_at(c);
    expect_at(c + 10, 1'b1, 1'b1, 2'd2, "R5");
    expect_at(c + TS + 1, 1'b1, 1'b1, 2'd3, "R5");
    expect_at(c + 35, 1'b1, 1'b1, 2'd3, "R5");
    expect_at(c + 36, 1'b0, 1'b1, 2'd0, "R5");
    wait_to(c + 5);  idp_lvl = 1'b1;
    wait_to(c + 8);  idp_lvl = 1'b0;
    wait_to(c + 30); idp_lvl = 1'b1;
    wait_to(c + 35); idp_lvl = 1'b0;
    drain();

    // R6 mode 1 identity closes on second delayed pulse
    arm_gate(2'b00, 1'b1, 1'b0, "R2");
    c = cyc + 3;
    frm_at(c);
    expect_at(c + TS + 3, 1'b1, 1'b1, 2'd3, "R6");
    frm_at(c + 30);
    expect_at(c + 30 + TS,     1'b1, 1'b0, 2'd0, "R6");
    expect_at(c + 30 + TS + 1, 1'b0, 1'b1, 2'd0, "R6");
    drain();

    // R7 emergency in mode 1 with ident set, spaced trains
    arm_gate(2'b00, 1'b1, 1'b1, "R2");
    c = cyc + 3;
    frm_at(c);
    frm_at(c + 25);
    frm_at(c + 50);
    expect_at(c + 72, 1'b1, 1'b0, 2'd0, "R7");
    frm_at(c + 75);
    expect_at(c + 75 + TS,     1'b1, 1'b0, 2'd0, "R7");
    expect_at(c + 75 + TS + 1, 1'b0, 1'b1, 2'd0, "R7");
    drain();

    // R7 emergency in mode 3, overlapping delayed copies
    arm_gate(2'b01, 1'b0, 1'b1, "R2");
    c = cyc + 3;
    frm_at(c);
    frm_at(c + 10);
    frm_at(c + 20);
    expect_at(c + 40, 1'b1, 1'b1, 2'd3, "R7");
    frm_at(c + 30);
    expect_at(c + 30 + TS,     1'b1, 1'b0, 2'd0, "R7");
    expect_at(c + 30 + TS + 1, 1'b0, 1'b1, 2'd0, "R7");
    drain();

    // R8 framing pulse after the window closed
    c = cyc + 2;
    frm_at(c);
    expect_at(c + 30, 1'b0, 1'b1, 2'd0, "R8");
    drain();

    // R9 re-arm mid reply discards pending taps
    arm_gate(2'b01, 1'b0, 1'b0, "R2");
    c = cyc + 3;
    frm_at(c);
    wait_to(c + 10);
    arm_gate(2'b01, 1'b0, 1'b0, "R9");
    expect_at(c + TS + 1, 1'b1, 1'b1, 2'd1, "R9");
    frm_at(c + 30);
    expect_at(c + 30 + TS,     1'b1, 1'b0, 2'd0, "R9");
    expect_at(c + 30 + TS + 1, 1'b0, 1'b1, 2'd0, "R9");
    drain();

    // R10 ten missing ticks delay the altitude close by ten cycles
    arm_gate(2'b10, 1'b0, 1'b0, "R2");
    c = cyc + 3;
    frm_at(c);
    expect_at(c + TL + 10,     1'b1, 1'b0, 2'd0, "R10");
    expect_at(c + TL + 11, 1'b0, 1'b1, 2'd0, "R10");
    wait_to(c + 5);  tick = 1'b0;
    wait_to(c + 15); tick = 1'b1;
    drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule